// File: doc/BRIEF.md
# Eight-Tap Fractional-Sample Interpolation Filter

This block computes fractional-position luma samples for motion-compensated prediction. It takes 8-bit reference samples one at a time and keeps the eight most recent of them in a sliding window. For each new sample it produces one signed 16-bit intermediate result. The taps come from one of three fixed 8-tap sets, chosen by a 2-bit phase, and the sum is kept at full precision with no normalising shift. A fourth phase value selects the full-sample position: the fourth window sample is passed through, scaled by 64, so the result has the same format as the filtered phases.

A job starts with a one-cycle start pulse. The pulse carries the phase, the direction and the block dimensions, each from 1 to 64. The block handles both directions with the same one-dimensional datapath.

- **Horizontal jobs:** the caller streams each row as `width + 7` samples, beginning three samples before the first target position. The block returns `width` results per row, for `height` rows.
- **Vertical jobs:** the caller streams each column top to bottom as `height + 7` samples, beginning three rows above the target. The block returns `height` results per column, for `width` columns.

The window refills at every new line. Inputs and results each use a valid/ready handshake.

Top module: `qpel_fir8`

## Requirements
- R1: While reset is held and after it is released, before any start, `out_valid` and `in_ready` are 0.
- R2: Phase 1 result: `-a + 4b - 10c + 58d + 17e - 5f + g`. Here `a` is the oldest and `h` the newest of the eight samples in the window after the current sample is accepted.
- R3: Phase 2 result: `-a + 4b - 11c + 40d + 40e - 11f + 4g - h`.
- R4: Phase 3 result: `b - 5c + 17d + 58e - 10f + 4g - h`.
- R5: Phase 0 result: `64 * d`. Every phase-0 result is therefore non-negative and a multiple of 64.
- R6: A result is produced only when an input sample is accepted and that sample is at least the eighth sample of its line. A line of length L takes L+7 samples and yields L results. No sample of one line affects any result of the next line.
- R7: Once the last sample of the last line has been accepted, `in_ready` stays 0 and no further result appears until a new start. The total number of results is `width * height`.
- R8: A start pulse that arrives while a job is running is ignored. The running job keeps its phase, direction and dimensions.
- R9: While `out_valid` is 1 and `out_ready` is 0, the result is held: `out_valid` stays 1, `out_data` is unchanged, and no input sample is accepted.
- R10: When `cfg_vert` is 1, the line length is the height and the line count is the width. When `cfg_vert` is 0, the line length is the width and the line count is the height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | One-cycle job start, accepted only when idle |
| cfg_phase | input | 2 | 0 full sample, 1 quarter, 2 half, 3 three-quarter |
| cfg_vert | input | 1 | 1 selects vertical job geometry |
| cfg_width | input | 7 | Block width, 1 to 64 |
| cfg_height | input | 7 | Block height, 1 to 64 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | 8 | Unsigned reference sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 16 | Signed two's-complement result |

## Verification
The bench targets several corner cases, each with a distinct failure signature:

- **Line boundaries.** Every row or column uses fresh random samples. A window that carried old samples across a line, or a line length off by one, would mismatch at the first result of every line. It would also shift the total result count.
- **Extreme values.** All-255 and alternating 0/255 patterns push the positive and negative tap sums to their limits. A coefficient swap or truncated accumulator would show there.
- **Geometry.** Blocks of size 1x1 and 64x1 are run, along with vertical jobs whose width and height differ. A design that swapped the line length and line count in vertical mode would produce results in the wrong order and the wrong number of them.
- **Flow control.** Random output stalls and input gaps, together with a stray start pulse in mid-job, catch a dropped or overwritten result, a lost sample, or a job that restarts.

// File: rtl/qpel_fir8.sv
module qpel_fir8 #(
  parameter int SW   = 8,
  parameter int OW   = 16,
  parameter int DIMW = 7,
  parameter int TAPS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_start,
  input  logic [1:0]      cfg_phase,
  input  logic            cfg_vert,
  input  logic [DIMW-1:0] cfg_width,
  input  logic [DIMW-1:0] cfg_height,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [SW-1:0]   in_sample,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OW-1:0]   out_data
);
  localparam int PW = DIMW + 1;

  logic            busy;
  logic [1:0]      ph;
  logic [DIMW-1:0] len, lines_left;
  logic [PW-1:0]   pos;
  logic [SW-1:0]   win [TAPS];
  logic [SW-1:0]   nw  [TAPS];
  logic [OW-1:0]   acc;
  logic            take, line_end;

  function automatic int coef(input logic [1:0] p, input int k);
    case (p)
      2'd1: case (k)
              0: return -1;  1: return 4;   2: return -10; 3: return 58;
              4: return 17;  5: return -5;  6: return 1;   default: return 0;
            endcase
      2'd2: case (k)
              0: return -1;  1: return 4;   2: return -11; 3: return 40;
              4: return 40;  5: return -11; 6: return 4;   default: return -1;
            endcase
      2'd3: case (k)
              0: return 0;   1: return 1;   2: return -5;  3: return 17;
              4: return 58;  5: return -10; 6: return 4;   default: return -1;
            endcase
      default: return (k == 3) ? 64 : 0;
    endcase
  endfunction

  for (genvar g = 0; g < TAPS - 1; g++) begin : g_shift
    assign nw[g] = win[g+1];
  end
  assign nw[TAPS-1] = in_sample;

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + OW'(coef(ph, k) * int'(nw[k]));
  end

  assign in_ready = busy && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;
  assign line_end = (pos == PW'(len) + PW'(TAPS - 2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      ph         <= '0;
      len        <= '0;
      lines_left <= '0;
      pos        <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      for (int k = 0; k < TAPS; k++) win[k] <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!busy && cfg_start) begin
        busy       <= 1'b1;
        ph         <= cfg_phase;
        len        <= cfg_vert ? cfg_height : cfg_width;
        lines_left <= cfg_vert ? cfg_width : cfg_height;
        pos        <= '0;
      end
      if (take) begin
        for (int k = 0; k < TAPS; k++) win[k] <= nw[k];
        if (pos >= PW'(TAPS - 1)) begin
          out_data  <= acc;
          out_valid <= 1'b1;
        end
        if (line_end) begin
          pos <= '0;
          if (lines_left == DIMW'(1)) busy <= 1'b0;
          else lines_left <= lines_left - DIMW'(1);
        end else begin
          pos <= pos + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/qpel_fir8_chk.sv
module qpel_fir8_chk #(
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_start,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          busy,
  input logic [1:0]    ph
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6
  new_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  // R5
  full_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ph == 2'd0 |-> out_data[5:0] == 6'd0 && !out_data[OW-1]);

  // R8
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_start |=> $stable(ph));
endmodule

bind qpel_fir8 qpel_fir8_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .busy(busy), .ph(ph)
);

// File: tb/qpel_fir8_bench.sv
module qpel_fir8_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_start = 0;
  logic [1:0] cfg_phase = 0;
  logic cfg_vert = 0;
  logic [6:0] cfg_width = 0, cfg_height = 0;
  logic in_valid = 0, out_ready = 0;
  logic [7:0] in_sample = 0;
  logic in_ready, out_valid;
  logic [15:0] out_data;

  int total = 0, bad = 0;
  int pic [71][71];

  always #4 clk = ~clk;

  qpel_fir8 u_qpel_fir8 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_phase(cfg_phase),
    .cfg_vert(cfg_vert), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int tapv(int p, int k);
    int q1 [8] = '{-1, 4, -10, 58, 17, -5, 1, 0};
    int q2 [8] = '{-1, 4, -11, 40, 40, -11, 4, -1};
    if (p == 0) return (k == 3) ? 64 : 0;
    if (p == 1) return q1[k];
    if (p == 2) return q2[k];
    return q1[7-k];
  endfunction

  function automatic string ptag(int p);
    case (p)
      0: return "R5";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run(int p, bit vert, int w, int h, int pat, bit bp, bit inject);
    int stream[$];
    int expq[$];
    int idx = 0, oc = 0, held = 0;
    bit hold = 0, seen = 0;
    string tag = vert ? {ptag(p), "/R10"} : ptag(p);
    for (int r = 0; r < 71; r++)
      for (int c = 0; c < 71; c++)
        pic[r][c] = (pat == 0) ? int'($urandom % 256) :
                    (pat == 1) ? 255 : (((r + c) % 2) * 255);
    if (!vert) begin
      for (int r = 0; r < h; r++) begin
        for (int c = 0; c < w + 7; c++) stream.push_back(pic[r+3][c]);
        for (int x = 0; x < w; x++) begin
          int s = 0;
          for (int k = 0; k < 8; k++) s += tapv(p, k) * pic[r+3][x+k];
          expq.push_back(s);
        end
      end
    end else begin
      for (int x = 0; x < w; x++) begin
        for (int y = 0; y < h + 7; y++) stream.push_back(pic[y][x+3]);
        for (int y = 0; y < h; y++) begin
          int s = 0;
          for (int k = 0; k < 8; k++) s += tapv(p, k) * pic[y+k][x+3];
          expq.push_back(s);
        end
      end
    end
    @(negedge clk);
    cfg_phase = 2'(p); cfg_vert = vert; cfg_width = 7'(w); cfg_height = 7'(h);
    cfg_start = 1;
    @(negedge clk);
    cfg_start = 0;
    while (idx < stream.size() || oc < expq.size()) begin
      in_valid  = (idx < stream.size()) && (!bp || ($urandom % 4 != 0));
      in_sample = (idx < stream.size()) ? 8'(stream[idx]) : 8'd0;
      out_ready = !bp || ($urandom % 3 != 0);
      cfg_start = inject && (idx == stream.size() / 2);
      cfg_phase = 2'(p + 1); cfg_vert = !vert; cfg_width = 7'd3; cfg_height = 7'd2;
      #1;
      if (hold) check(out_valid && out_data == 16'(held), "R9", int'(out_data), held);
      if (out_valid && !seen) begin
        seen = 1;
        check(idx >= 8, "R6 first result", idx, 8);
      end
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        int e = (oc < expq.size()) ? expq[oc] : 0;
        check(oc < expq.size() && $signed(out_data) == e, tag, int'($signed(out_data)), e);
        oc++;
      end
      hold = out_valid && !out_ready;
      held = int'(out_data);
      @(negedge clk);
    end
    cfg_start = 0;
    in_valid = 1;
    out_ready = 1;
    #1;
    check(in_ready == 0, "R7 idle in_ready", int'(in_ready), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check(!out_valid && !in_ready, "R7 no extra result", int'(out_valid), 0);
    end
    check(oc == w * h, "R6 result count", oc, w * h);
    in_valid = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready, "R1 in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(!out_valid && !in_ready, "R1 after reset", int'(in_ready), 0);
    run(1, 0, 8, 2, 0, 0, 0);
    run(2, 0, 4, 3, 0, 1, 0);
    run(3, 1, 8, 4, 0, 1, 0);
    run(0, 1, 5, 2, 0, 1, 0);
    run(2, 1, 1, 1, 1, 0, 0);
    run(1, 0, 64, 1, 2, 1, 0);
    run(3, 0, 6, 2, 2, 0, 0);
    run(2, 0, 5, 3, 2, 1, 0);
    run(1, 1, 3, 9, 0, 1, 1);
    run(0, 0, 7, 2, 1, 0, 1);
    run(2, 1, 16, 16, 0, 1, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule